// File: doc/BRIEF.md
# Quadrature Encoder Register Block

This block is the software-visible register file of a quadrature encoder peripheral. It sits on a simple 32-bit read/write bus and decodes ten word offsets. It holds the configuration that the input filter and the position counter cores run from, and it presents the live count that the counter core produces. Configuration is locked while the peripheral runs: the filter length, the ceiling and the control fields can change only while the enable bit is clear. A control write that clears enable applies at once, so the next bus access already sees an unlocked block.

Six event pulses from the cores are caught in sticky status bits. Software clears a status bit by writing 1 to it. A mask register selects which pending bits reach the single interrupt line. The watchdog, capture divider, counter and capture buffer registers are plain read/write storage here, because the timer and FIFO data paths that use them live elsewhere.

Top module: `qenc_regs`

## Requirements
- R1: After reset every register reads zero while `count_i`, `fifo_empty_i` and `phase_err_i` are low, `irq_o` is low and all configuration outputs are zero.
- R2: The words at 0x10, 0x14, 0x18 and 0x1C store all 32 written bits each and read them back independently of one another.
- R3: The control word at 0x00 maps its fields as follows. Bit 0 is enable. Bit 1 is filter enable. Bits 2, 3 and 4 are the edge selects for phase A, phase B and index. Bit 5 is the A/B swap. Bit 6 is the operating mode. Bit 8 is the reset mode. Bits 10:9 are the index gating. Bit 11 is the capture mode. Bits 14:12 are the FIFO threshold code. Each field drives its matching output, and bits 31:16 read zero.
- R4: The filter word at 0x04 keeps its low 21 bits, drives `filt_len_o` with them and reads zero above them.
- R5: The ceiling word at 0x0C keeps all 32 bits and drives `ceiling_o`.
- R6: While enable is 1, writes to the filter and ceiling words leave them unchanged.
- R7: While enable is 1, a control write changes only bit 0. A write that clears bit 0 unlocks the block before the next bus access.
- R8: Control bit 15 reads `fifo_empty_i` and bit 7 reads `phase_err_i`. Writes to these two bits have no effect.
- R9: The word at 0x08 reads `count_i`, and writes to it have no effect.
- R10: A pulse on bit k of `evt_i` sets bit k of the status word at 0x20, and the bit stays set. The bits are: 0 watchdog, 1 reset while counting down, 2 reset while counting up, 3 direction change, 4 FIFO entry, 5 FIFO critical.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an event arrives in the same cycle as the clear, the event wins.
- R12: The mask word at 0x24 keeps 6 bits. `irq_o` is high exactly when some status bit is set whose mask bit is 0, so writing 0x3F silences it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid in the same cycle |
| count_i | input | 32 | Live count from the counter core |
| fifo_empty_i | input | 1 | Capture FIFO empty flag |
| phase_err_i | input | 1 | Phase error flag from the decoder |
| evt_i | input | 6 | Event pulses from the cores |
| enable_o | output | 1 | Peripheral enable |
| filt_en_o | output | 1 | Spike filter enable |
| edge_sel_o | output | 3 | Edge selects for A, B and index |
| swap_ab_o | output | 1 | Swap phases A and B |
| op_mode_o | output | 1 | Operating mode |
| rst_mode_o | output | 1 | Count reset mode |
| idx_gate_o | output | 2 | Index gating select |
| cap_mode_o | output | 1 | Capture mode |
| fifo_thr_o | output | 3 | FIFO threshold code (level minus one) |
| filt_len_o | output | 21 | Filter length |
| ceiling_o | output | 32 | Count ceiling |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions watch four things on every cycle. The filter, ceiling and control fields stay stable whenever the block is enabled. Every event pulse leaves its status bit set. A fully set mask keeps the interrupt low. Control reads always carry the two live status inputs. Only the bench scenarios can show the rest: the address map, the field positions, write-one-to-clear, the event beating a clear in the same cycle, and the unlock taking effect by the very next access.

// File: rtl/qenc_pkg.sv
// Shared constants for the encoder register block.
// Assumes a 32-bit bus with word-aligned offsets.
package qenc_pkg;
    localparam int QE_DATA_W  = 32;
    localparam int QE_ADDR_W  = 6;
    localparam int QE_FILT_W  = 21;
    localparam int QE_NUM_EVT = 6;
    localparam int QE_NUM_REG = 10;

    // Word indices (byte offset / 4)
    localparam int IX_CTRL   = 0;
    localparam int IX_FILT   = 1;
    localparam int IX_COUNT  = 2;
    localparam int IX_CEIL   = 3;
    localparam int IX_WDOG   = 4;
    localparam int IX_CAPDIV = 5;
    localparam int IX_CNTR   = 6;
    localparam int IX_CAPBUF = 7;
    localparam int IX_ISTAT  = 8;
    localparam int IX_IMASK  = 9;

    // Plain storage words are contiguous
    localparam int STORE_LO  = IX_WDOG;
    localparam int NUM_STORE = IX_CAPBUF - IX_WDOG + 1;

    // Lockable control fields (enable is held separately)
    typedef struct packed {
        logic [2:0] fifo_thr;
        logic       cap_mode;
        logic [1:0] idx_gate;
        logic       rst_mode;
        logic       op_mode;
        logic       swap_ab;
        logic [2:0] edge_sel;
        logic       filt_en;
    } ctrl_cfg_t;
endpackage

// File: rtl/qenc_addr_dec.sv
// Address decoder: turns the byte address into a word index and one
// write strobe per register. Assumes bits 1:0 of the address are don't-care.
module qenc_addr_dec #(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 10,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [IDX_W-1:0]    word_idx,
    output logic [NUM_REGS-1:0] wr_stb
);
    logic [1:0] unused_lo;

    // Word index from the aligned part of the address
    assign word_idx  = bus_addr[ADDR_W-1:2];
    assign unused_lo = bus_addr[1:0];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_stb
            // One write strobe per register word
            assign wr_stb[gi] = bus_sel && bus_wr && (word_idx == IDX_W'(gi));
        end
    endgenerate
endmodule

// File: rtl/qenc_cfg_regs.sv
// Lockable configuration: control fields, filter length and ceiling.
// While enable is set only the enable bit accepts writes.
module qenc_cfg_regs
    import qenc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FILT_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              filt_wr,
    input  logic              ceil_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              enable_q,
    output ctrl_cfg_t         cfg_q,
    output logic [FILT_W-1:0] filt_q,
    output logic [DATA_W-1:0] ceil_q
);
    ctrl_cfg_t   cfg_d;
    logic [DATA_W-1:0] unused_wd;

    assign unused_wd = wdata;

    // Unpack the control write data; bits 7 and 15 are skipped (read-only)
    always_comb begin
        cfg_d.filt_en  = wdata[1];
        cfg_d.edge_sel = wdata[4:2];
        cfg_d.swap_ab  = wdata[5];
        cfg_d.op_mode  = wdata[6];
        cfg_d.rst_mode = wdata[8];
        cfg_d.idx_gate = wdata[10:9];
        cfg_d.cap_mode = wdata[11];
        cfg_d.fifo_thr = wdata[14:12];
    end

    // Register updates, gated by the current enable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            cfg_q    <= '0;
            filt_q   <= '0;
            ceil_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                enable_q <= wdata[0];
                if (!enable_q) cfg_q <= cfg_d;
            end
            if (filt_wr && !enable_q) filt_q <= wdata[FILT_W-1:0];
            if (ceil_wr && !enable_q) ceil_q <= wdata;
        end
    end
endmodule

// File: rtl/qenc_store_bank.sv
// Bank of plain read/write words with no side effects.
module qenc_store_bank #(
    parameter int DATA_W = 32,
    parameter int NUM    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM-1:0]             wr_stb,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM-1:0][DATA_W-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM; gi++) begin : g_word
            // One storage word, loaded on its strobe
            always_ff @(posedge clk) begin
                if (!rst_n)          q[gi] <= '0;
                else if (wr_stb[gi]) q[gi] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/qenc_irq_ctl.sv
// Sticky event status with write-one-to-clear, a mask and one interrupt.
// An event arriving with a clear in the same cycle wins.
module qenc_irq_ctl #(
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               stat_wr,
    input  logic               mask_wr,
    input  logic [NUM_EVT-1:0] wbits,
    output logic [NUM_EVT-1:0] stat_q,
    output logic [NUM_EVT-1:0] mask_q,
    output logic               irq_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_bit
            // Status bit: set by event, cleared by a 1 written to it
            always_ff @(posedge clk) begin
                if (!rst_n)                     stat_q[gi] <= 1'b0;
                else if (evt_i[gi])             stat_q[gi] <= 1'b1;
                else if (stat_wr && wbits[gi])  stat_q[gi] <= 1'b0;
            end
        end
    endgenerate

    // Mask register load
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wbits;
    end

    // Interrupt from pending unmasked bits
    assign irq_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/qenc_regs.sv
// Top of the encoder register block: decoder, lockable configuration,
// storage words and interrupt logic, plus the combinational read mux.
// Assumes single-cycle bus accesses with read data taken in the same cycle.
module qenc_regs
    import qenc_pkg::*;
#(
    parameter int DATA_W  = QE_DATA_W,
    parameter int ADDR_W  = QE_ADDR_W,
    parameter int FILT_W  = QE_FILT_W,
    parameter int NUM_EVT = QE_NUM_EVT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  count_i,
    input  logic               fifo_empty_i,
    input  logic               phase_err_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               enable_o,
    output logic               filt_en_o,
    output logic [2:0]         edge_sel_o,
    output logic               swap_ab_o,
    output logic               op_mode_o,
    output logic               rst_mode_o,
    output logic [1:0]         idx_gate_o,
    output logic               cap_mode_o,
    output logic [2:0]         fifo_thr_o,
    output logic [FILT_W-1:0]  filt_len_o,
    output logic [DATA_W-1:0]  ceiling_o,
    output logic               irq_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]                word_idx;
    logic [QE_NUM_REG-1:0]           wr_stb;
    ctrl_cfg_t                       cfg_q;
    logic [NUM_STORE-1:0][DATA_W-1:0] store_q;
    logic [NUM_EVT-1:0]              stat_q;
    logic [NUM_EVT-1:0]              mask_q;
    logic [15:0]                     ctrl_rd;

    qenc_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(QE_NUM_REG)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .word_idx (word_idx),
        .wr_stb   (wr_stb)
    );

    qenc_cfg_regs #(.DATA_W(DATA_W), .FILT_W(FILT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (wr_stb[IX_CTRL]),
        .filt_wr  (wr_stb[IX_FILT]),
        .ceil_wr  (wr_stb[IX_CEIL]),
        .wdata    (bus_wdata),
        .enable_q (enable_o),
        .cfg_q    (cfg_q),
        .filt_q   (filt_len_o),
        .ceil_q   (ceiling_o)
    );

    qenc_store_bank #(.DATA_W(DATA_W), .NUM(NUM_STORE)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb[STORE_LO +: NUM_STORE]),
        .wdata  (bus_wdata),
        .q      (store_q)
    );

    qenc_irq_ctl #(.NUM_EVT(NUM_EVT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .stat_wr (wr_stb[IX_ISTAT]),
        .mask_wr (wr_stb[IX_IMASK]),
        .wbits   (bus_wdata[NUM_EVT-1:0]),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .irq_o   (irq_o)
    );

    // Fan the control fields out to the cores
    assign filt_en_o  = cfg_q.filt_en;
    assign edge_sel_o = cfg_q.edge_sel;
    assign swap_ab_o  = cfg_q.swap_ab;
    assign op_mode_o  = cfg_q.op_mode;
    assign rst_mode_o = cfg_q.rst_mode;
    assign idx_gate_o = cfg_q.idx_gate;
    assign cap_mode_o = cfg_q.cap_mode;
    assign fifo_thr_o = cfg_q.fifo_thr;

    // Control word as read back, with the two live status bits merged in
    assign ctrl_rd = {fifo_empty_i, cfg_q.fifo_thr, cfg_q.cap_mode, cfg_q.idx_gate,
                      cfg_q.rst_mode, phase_err_i, cfg_q.op_mode, cfg_q.swap_ab,
                      cfg_q.edge_sel, cfg_q.filt_en, enable_o};

    // Read mux; zero when no read is requested or the offset is unused
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (word_idx)
                IDX_W'(IX_CTRL):   bus_rdata = {{(DATA_W-16){1'b0}}, ctrl_rd};
                IDX_W'(IX_FILT):   bus_rdata = {{(DATA_W-FILT_W){1'b0}}, filt_len_o};
                IDX_W'(IX_COUNT):  bus_rdata = count_i;
                IDX_W'(IX_CEIL):   bus_rdata = ceiling_o;
                IDX_W'(IX_WDOG):   bus_rdata = store_q[IX_WDOG - STORE_LO];
                IDX_W'(IX_CAPDIV): bus_rdata = store_q[IX_CAPDIV - STORE_LO];
                IDX_W'(IX_CNTR):   bus_rdata = store_q[IX_CNTR - STORE_LO];
                IDX_W'(IX_CAPBUF): bus_rdata = store_q[IX_CAPBUF - STORE_LO];
                IDX_W'(IX_ISTAT):  bus_rdata = {{(DATA_W-NUM_EVT){1'b0}}, stat_q};
                IDX_W'(IX_IMASK):  bus_rdata = {{(DATA_W-NUM_EVT){1'b0}}, mask_q};
                default:           bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/qenc_regs_chk.sv
// Property checker for qenc_regs, attached through bind below.
module qenc_regs_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int FILT_W  = 21,
    parameter int NUM_EVT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               fifo_empty_i,
    input logic               phase_err_i,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               enable_o,
    input logic [13:0]        cfg_vec,
    input logic [FILT_W-1:0]  filt_len_o,
    input logic [DATA_W-1:0]  ceiling_o,
    input logic [NUM_EVT-1:0] stat_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic               irq_o
);
    logic rd_ctrl;
    assign rd_ctrl = bus_sel && !bus_wr && (bus_addr[ADDR_W-1:2] == '0);

    // R6
    filt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o |=> $stable(filt_len_o));

    // R6
    ceil_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o |=> $stable(ceiling_o));

    // R7
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o |=> $stable(cfg_vec));

    // R10
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R12
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_o);

    // R8
    live_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> (bus_rdata[15] == fifo_empty_i && bus_rdata[7] == phase_err_i));
endmodule

bind qenc_regs qenc_regs_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILT_W(FILT_W), .NUM_EVT(NUM_EVT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .fifo_empty_i (fifo_empty_i),
    .phase_err_i  (phase_err_i),
    .evt_i        (evt_i),
    .enable_o     (enable_o),
    .cfg_vec      ({fifo_thr_o, cap_mode_o, idx_gate_o, rst_mode_o, op_mode_o,
                    swap_ab_o, edge_sel_o, filt_en_o}),
    .filt_len_o   (filt_len_o),
    .ceiling_o    (ceiling_o),
    .stat_q       (stat_q),
    .mask_q       (mask_q),
    .irq_o        (irq_o)
);

// File: tb/tb_qenc_regs.sv
// Scoreboard bench: read tasks queue the expected word, a monitor compares.
module tb_qenc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, count_i = '0, ceiling_o;
    logic        fifo_empty_i = 1'b0, phase_err_i = 1'b0;
    logic [5:0]  evt_i = '0;
    logic        enable_o, filt_en_o, swap_ab_o, op_mode_o, rst_mode_o, cap_mode_o, irq_o;
    logic [2:0]  edge_sel_o, fifo_thr_o;
    logic [1:0]  idx_gate_o;
    logic [20:0] filt_len_o;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    qenc_regs dut (.*);

    // Monitor: pop and compare each queued read
    initial forever begin
        @(mon_ev);
        begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s read actual %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sb_q.push_back('{exp, tag});
        #1 -> mon_ev;
        #0.5 bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk); evt_i = e;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_pins();
        return {18'b0, fifo_thr_o, cap_mode_o, idx_gate_o, rst_mode_o, op_mode_o,
                swap_ab_o, edge_sel_o, filt_en_o, enable_o};
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word and output
        for (int i = 0; i < 10; i++) rd(6'(i * 4), 32'h0, "R1");
        chk({31'b0, irq_o}, 0, "R1 irq");
        chk(cfg_pins(), 0, "R1 cfg");
        chk(ceiling_o | 32'(filt_len_o), 0, "R1 filt/ceil");

        // R2: storage words
        wr(6'h10, 32'h1111_AAAA); wr(6'h14, 32'h2222_5555);
        wr(6'h18, 32'hFFFF_0000); wr(6'h1C, 32'h8000_0001);
        rd(6'h10, 32'h1111_AAAA, "R2 wdog"); rd(6'h14, 32'h2222_5555, "R2 capdiv");
        rd(6'h18, 32'hFFFF_0000, "R2 cntr"); rd(6'h1C, 32'h8000_0001, "R2 capbuf");

        // R3 / R8: control fields and read-only bits
        wr(6'h00, 32'hFFFF_FFFE);
        rd(6'h00, 32'h0000_7F7E, "R3 ctrl");
        chk(cfg_pins(), 32'h3FFE, "R3 pins");
        fifo_empty_i = 1'b1; phase_err_i = 1'b1;
        rd(6'h00, 32'h0000_FFFE, "R8 live bits");
        fifo_empty_i = 1'b0; phase_err_i = 1'b0;

        // R4 / R5: filter and ceiling
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, 32'h001F_FFFF, "R4 filt");
        chk(32'(filt_len_o), 32'h001F_FFFF, "R4 pin");
        wr(6'h0C, 32'hDEAD_BEEF);
        rd(6'h0C, 32'hDEAD_BEEF, "R5 ceil");
        chk(ceiling_o, 32'hDEAD_BEEF, "R5 pin");

        // R6 / R7: lock while enabled
        wr(6'h00, 32'h0000_0105);
        rd(6'h00, 32'h0000_0105, "R7 enable write");
        wr(6'h04, 32'h0000_0055);
        rd(6'h04, 32'h001F_FFFF, "R6 filt locked");
        wr(6'h0C, 32'h0000_1234);
        rd(6'h0C, 32'hDEAD_BEEF, "R6 ceil locked");
        wr(6'h00, 32'h0000_7FFF);
        rd(6'h00, 32'h0000_0105, "R7 ctrl locked");
        wr(6'h00, 32'h0000_0000);
        rd(6'h00, 32'h0000_0104, "R7 disable");
        wr(6'h04, 32'h0000_0055);
        rd(6'h04, 32'h0000_0055, "R7 unlocked filt");
        wr(6'h0C, 32'h0000_1234);
        rd(6'h0C, 32'h0000_1234, "R7 unlocked ceil");

        // R9: live count, read-only
        count_i = 32'hA5A5_0001;
        rd(6'h08, 32'hA5A5_0001, "R9 count");
        wr(6'h08, 32'hFFFF_FFFF);
        count_i = 32'h0000_0042;
        rd(6'h08, 32'h0000_0042, "R9 count after write");

        // R10 / R11 / R12: status, clear, mask
        pulse(6'h08);
        rd(6'h20, 32'h08, "R10 dir event");
        chk({31'b0, irq_o}, 1, "R12 irq unmasked");
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, 32'h3F, "R12 mask width");
        chk({31'b0, irq_o}, 0, "R12 all masked");
        wr(6'h24, 32'h37);
        chk({31'b0, irq_o}, 1, "R12 bit3 unmasked");
        wr(6'h20, 32'h00);
        rd(6'h20, 32'h08, "R11 write 0 keeps");
        wr(6'h20, 32'h08);
        rd(6'h20, 32'h00, "R11 write 1 clears");
        chk({31'b0, irq_o}, 0, "R11 irq after clear");
        pulse(6'h21);
        rd(6'h20, 32'h21, "R10 two events");
        chk({31'b0, irq_o}, 0, "R12 pending but masked");
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h21; evt_i = 6'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_i = '0;
        rd(6'h20, 32'h01, "R11 event beats clear");
        wr(6'h24, 32'h36);
        chk({31'b0, irq_o}, 1, "R12 bit0 unmasked");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule